// File: doc/BRIEF.md
# Serial Flash Status-Register Protection Controller

This block holds the status byte of a serial NOR flash and decides, one command at a time, whether a state-changing command may run. An upstream SPI front end hands it commands that are already decoded, together with the six writable status bits carried by a write-status command. Alongside each command come three inputs: the write-protect pin level, a flag that says whether the target address falls inside the block-protected region, and a flag that selects the one-time-programmable (OTP) sector mode. The block replies one cycle later with an accept or reject decision.

For an accepted program or erase, the block raises a one-cycle start pulse toward the array engine and stays busy until that engine returns a done strobe. For an accepted write-status command, the block times the busy period itself with a fixed cycle count. A write-enable latch guards every write. The block-protect field, a status-protect bit combined with the pin, and a sticky OTP lock each narrow further what is allowed.

Top module: `flash_sr_guard`

## Requirements
- R1: The status byte is, from bit 7 to bit 0: bit 7 (status-protect bit outside OTP mode, OTP lock inside OTP mode), pin-disable bit, protect field PB3..PB0, write-enable latch (WEL), busy (WIP). Every stored bit resets to 0.
- R2: A command presented with cmd_valid high at a clock edge gives rsp_valid=1 in the following cycle, with rsp_accept and rsp_data. rsp_data is the status byte as it stood at that edge. Without cmd_valid, rsp_valid is 0 and rsp_data is 0. The op codes are 0 none, 1 write-enable, 2 write-disable, 3 write-status, 4 read-status, 5 page program, 6 sector erase, 7 block erase, 8 chip erase. Codes 0 and 9..15 are rejected and change nothing.
- R3: Write-enable sets WEL and write-disable clears it. Both are accepted when the block is idle, as is read-status.
- R4: While WEL is 0, write-status, program and all erase commands are rejected and nothing starts.
- R5: An accepted write-status command loads status bits 7..2 from cmd_wdata[5:0] (bit 5 is the status-protect bit, bit 4 the pin-disable bit, bits 3:0 PB3..PB0). WIP then reads 1 for exactly WRSR_CYCLES cycles, after which WIP and WEL both clear.
- R6: Outside OTP mode, page program, sector erase and block erase are rejected when PB is nonzero and in_region is 1, and accepted otherwise (given WEL). An accepted command pulses arr_start for one cycle and holds WIP until array_done, which then clears WIP and WEL.
- R7: Outside OTP mode, chip erase is accepted only when all four PB bits are 0.
- R8: When the status-protect bit is 1, wp_n is 0 and the pin-disable bit is 0, write-status is rejected and the stored status bits stay unchanged.
- R9: When the pin-disable bit is 1, wp_n has no effect: write-status is accepted with wp_n low.
- R10: In OTP mode, an accepted write-status command ignores cmd_wdata, sets the OTP lock to 1, and leaves the status-protect bit, the pin-disable bit and PB unchanged.
- R11: The OTP lock never returns to 0 after it is set, outside OTP mode as well. In OTP mode, every program and erase command is rejected while the lock is 1 and allowed (given WEL) while it is 0, whatever PB and in_region are.
- R12: While WIP is 1, only read-status is accepted. All other commands are rejected and change no state.
- R13: A write-status, program or erase command that is rejected while the block is idle clears WEL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Command code (see R2) |
| cmd_wdata | input | BP_W+2 | Status bits 7..2 carried by write-status |
| otp_mode | input | 1 | OTP sector mode selected |
| wp_n | input | 1 | Write-protect pin, active low |
| in_region | input | 1 | Target address lies in the block-protected region |
| array_done | input | 1 | Array engine finished a program or erase |
| status | output | BP_W+4 | Current status byte |
| busy | output | 1 | Copy of WIP |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_accept | output | 1 | That command was accepted |
| rsp_data | output | BP_W+4 | Status byte at the time of that command |
| arr_start | output | 1 | One-cycle start pulse to the array engine |

## Verification
Directed sequences walk the protection rules in pairs that differ in one input only. Program is tried with the region flag set and clear, chip erase with PB zero and nonzero, and write-status with the pin low, once with the pin-disable bit clear and once with it set. These pairs separate each gate from the others. OTP-mode cases compare the lock bit before and after a data-ignoring write-status, and leave OTP mode to show the lock persists and the other bits were untouched. Commands are also issued while busy, by both the internal write-status timer and the external done handshake, and a long pseudo-random command stream with random pin, region and mode inputs is compared against a behavioural model every cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_WREN  = 4'd1,
    OP_WRDI  = 4'd2,
    OP_WRSR  = 4'd3,
    OP_RDSR  = 4'd4,
    OP_PROG  = 4'd5,
    OP_SERA  = 4'd6,
    OP_BERA  = 4'd7,
    OP_CERA  = 4'd8
  } fsr_op_e;

  typedef struct packed {
    logic accept;
    logic set_wel;
    logic clr_wel;
    logic load_sr;
    logic start_arr;
  } fsr_dec_t;

endpackage

// File: rtl/fsr_cmd_judge.sv
module fsr_cmd_judge
  import fsr_pkg::*;
#(
  parameter int BP_W = 4
) (
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic            wip,
  input  logic            wel,
  input  logic            srp,
  input  logic            wpdis,
  input  logic [BP_W-1:0] bp,
  input  logic            otp_lock,
  input  logic            otp_mode,
  input  logic            wp_n,
  input  logic            in_region,
  output fsr_dec_t        dec
);

  logic hw_locked;
  logic region_ok;
  logic chip_ok;

  always_comb begin
    hw_locked = srp & ~wp_n & ~wpdis;
    region_ok = otp_mode ? ~otp_lock : ~((|bp) & in_region);
    chip_ok   = otp_mode ? ~otp_lock : ~(|bp);
  end

  always_comb begin
    dec = '0;
    if (cmd_valid) begin
      if (wip) begin
        dec.accept = (fsr_op_e'(cmd_op) == OP_RDSR);
      end else begin
        unique case (fsr_op_e'(cmd_op))
          OP_WREN: begin
            dec.accept  = 1'b1;
            dec.set_wel = 1'b1;
          end
          OP_WRDI: begin
            dec.accept  = 1'b1;
            dec.clr_wel = 1'b1;
          end
          OP_RDSR: dec.accept = 1'b1;
          OP_WRSR: begin
            dec.accept  = wel & ~hw_locked;
            dec.load_sr = wel & ~hw_locked;
            dec.clr_wel = ~(wel & ~hw_locked);
          end
          OP_PROG, OP_SERA, OP_BERA: begin
            dec.accept    = wel & region_ok;
            dec.start_arr = wel & region_ok;
            dec.clr_wel   = ~(wel & region_ok);
          end
          OP_CERA: begin
            dec.accept    = wel & chip_ok;
            dec.start_arr = wel & chip_ok;
            dec.clr_wel   = ~(wel & chip_ok);
          end
          default: dec = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/fsr_nv_store.sv
module fsr_nv_store #(
  parameter int BP_W = 4,
  localparam int WR_W = BP_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_sr,
  input  logic            otp_mode,
  input  logic [WR_W-1:0] wr_bits,
  output logic            srp,
  output logic            wpdis,
  output logic [BP_W-1:0] bp,
  output logic            otp_lock
);

  always_ff @(posedge clk) begin
    if (rst) begin
      srp      <= 1'b0;
      wpdis    <= 1'b0;
      bp       <= '0;
      otp_lock <= 1'b0;
    end else if (load_sr) begin
      if (otp_mode) begin
        otp_lock <= 1'b1;
      end else begin
        srp   <= wr_bits[WR_W-1];
        wpdis <= wr_bits[WR_W-2];
        bp    <= wr_bits[BP_W-1:0];
      end
    end
  end

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    otp_lock |=> otp_lock);

  assert_otp_keeps_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (load_sr && otp_mode) |=> ($stable(bp) && $stable(srp) && $stable(wpdis) && otp_lock));

endmodule

// File: rtl/fsr_wip_ctrl.sv
module fsr_wip_ctrl
  import fsr_pkg::*;
#(
  parameter int WRSR_CYCLES = 16,
  localparam int CNT_W = $clog2(WRSR_CYCLES + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  fsr_dec_t dec,
  input  logic     array_done,
  output logic     wel,
  output logic     wip,
  output logic     arr_start
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRSR_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             sr_cycle;
  logic [CNT_W-1:0] cnt;
  logic             finish;

  generate
    if (WRSR_CYCLES < 1) begin : g_bad_count
      initial $fatal(1, "WRSR_CYCLES must be at least 1");
    end
  endgenerate

  always_comb begin
    finish = wip & (sr_cycle ? (cnt == CNT_LAST) : array_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel       <= 1'b0;
      wip       <= 1'b0;
      sr_cycle  <= 1'b0;
      cnt       <= '0;
      arr_start <= 1'b0;
    end else begin
      arr_start <= 1'b0;
      if (dec.set_wel) wel <= 1'b1;
      if (dec.clr_wel) wel <= 1'b0;
      if (dec.load_sr) begin
        wip      <= 1'b1;
        sr_cycle <= 1'b1;
        cnt      <= CNT_LOAD;
      end else if (dec.start_arr) begin
        wip       <= 1'b1;
        sr_cycle  <= 1'b0;
        arr_start <= 1'b1;
      end else if (wip && sr_cycle) begin
        cnt <= cnt - CNT_LAST;
      end
      if (finish) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
    end
  end

  assert_start_means_busy_R6: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> (wip && wel));

  assert_no_start_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
    wip |-> !(dec.load_sr || dec.start_arr || dec.set_wel || dec.clr_wel));

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsr_pkg::*;
#(
  parameter int BP_W        = 4,
  parameter int WRSR_CYCLES = 16,
  localparam int WR_W = BP_W + 2,
  localparam int ST_W = BP_W + 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [WR_W-1:0] cmd_wdata,
  input  logic            otp_mode,
  input  logic            wp_n,
  input  logic            in_region,
  input  logic            array_done,
  output logic [ST_W-1:0] status,
  output logic            busy,
  output logic            rsp_valid,
  output logic            rsp_accept,
  output logic [ST_W-1:0] rsp_data,
  output logic            arr_start
);

  fsr_dec_t        dec;
  logic            wel, wip;
  logic            srp, wpdis, otp_lock;
  logic [BP_W-1:0] bp;

  fsr_cmd_judge #(.BP_W(BP_W)) u_judge (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wip       (wip),
    .wel       (wel),
    .srp       (srp),
    .wpdis     (wpdis),
    .bp        (bp),
    .otp_lock  (otp_lock),
    .otp_mode  (otp_mode),
    .wp_n      (wp_n),
    .in_region (in_region),
    .dec       (dec)
  );

  fsr_nv_store #(.BP_W(BP_W)) u_nv (
    .clk      (clk),
    .rst      (rst),
    .load_sr  (dec.load_sr),
    .otp_mode (otp_mode),
    .wr_bits  (cmd_wdata),
    .srp      (srp),
    .wpdis    (wpdis),
    .bp       (bp),
    .otp_lock (otp_lock)
  );

  fsr_wip_ctrl #(.WRSR_CYCLES(WRSR_CYCLES)) u_wip (
    .clk        (clk),
    .rst        (rst),
    .dec        (dec),
    .array_done (array_done),
    .wel        (wel),
    .wip        (wip),
    .arr_start  (arr_start)
  );

  always_comb begin
    status = {(otp_mode ? otp_lock : srp), wpdis, bp, wel, wip};
    busy   = wip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid  <= cmd_valid;
      rsp_accept <= dec.accept;
      rsp_data   <= cmd_valid ? status : '0;
    end
  end

  logic is_write_op;
  always_comb begin
    is_write_op = (cmd_op == OP_WRSR) || (cmd_op == OP_PROG) || (cmd_op == OP_SERA) ||
                  (cmd_op == OP_BERA) || (cmd_op == OP_CERA);
  end

  assert_wel_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && !status[1] && is_write_op) |=> (!rsp_accept && !busy));

  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy && cmd_op != OP_RDSR) |=> !rsp_accept);

  assert_chip_erase_bp_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && !otp_mode && cmd_op == OP_CERA && (|bp)) |=> !rsp_accept);

  assert_hw_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == OP_WRSR && srp && !wp_n && !wpdis)
      |=> (!rsp_accept && $stable(bp) && $stable(srp) && $stable(wpdis)));

  assert_rsp_follows_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!rsp_valid && !rsp_accept));

endmodule

// File: tb/tb_flash_sr_guard.sv
module tb_flash_sr_guard;
  localparam int CLK_P = 10;
  localparam int WRC   = 6;

  localparam logic [3:0] C_NONE = 4'd0, C_WREN = 4'd1, C_WRDI = 4'd2, C_WRSR = 4'd3,
                         C_RDSR = 4'd4, C_PP = 4'd5, C_SE = 4'd6, C_BE = 4'd7, C_CE = 4'd8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [5:0] cmd_wdata = 6'd0;
  logic       otp_mode = 1'b0;
  logic       wp_n = 1'b1;
  logic       in_region = 1'b0;
  logic       array_done = 1'b0;
  logic [7:0] status, rsp_data;
  logic       busy, rsp_valid, rsp_accept, arr_start;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit started = 0;

  flash_sr_guard #(.BP_W(4), .WRSR_CYCLES(WRC)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .otp_mode(otp_mode), .wp_n(wp_n), .in_region(in_region), .array_done(array_done),
    .status(status), .busy(busy), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .rsp_data(rsp_data), .arr_start(arr_start)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_wip, m_wel, m_srp, m_wpd, m_lock, m_sr, m_rv, m_acc, m_start;
  int m_bp, m_cnt, m_rdata;

  function automatic int mstat();
    return ((otp_mode ? m_lock : m_srp) << 7) | (m_wpd << 6) | (m_bp << 2) | (m_wel << 1) | m_wip;
  endfunction

  always @(posedge clk) begin
    bit fin, ok;
    int cur;
    started = 1;
    if (rst) begin
      m_wip = 0; m_wel = 0; m_srp = 0; m_wpd = 0; m_lock = 0; m_sr = 0;
      m_bp = 0; m_cnt = 0; m_rv = 0; m_acc = 0; m_start = 0; m_rdata = 0;
    end else begin
      cur = mstat();
      m_start = 0; m_acc = 0; m_rv = cmd_valid;
      m_rdata = cmd_valid ? cur : 0;
      fin = 0;
      if (m_wip) begin
        if (m_sr) begin m_cnt--; if (m_cnt == 0) fin = 1; end
        else if (array_done) fin = 1;
      end
      if (cmd_valid) begin
        if (m_wip) m_acc = (cmd_op == C_RDSR);
        else begin
          case (cmd_op)
            C_WREN: begin m_acc = 1; m_wel = 1; end
            C_WRDI: begin m_acc = 1; m_wel = 0; end
            C_RDSR: m_acc = 1;
            C_WRSR: begin
              ok = m_wel && !(m_srp && !wp_n && !m_wpd);
              if (ok) begin
                m_acc = 1; m_wip = 1; m_sr = 1; m_cnt = WRC;
                if (otp_mode) m_lock = 1;
                else begin m_srp = cmd_wdata[5]; m_wpd = cmd_wdata[4]; m_bp = cmd_wdata[3:0]; end
              end else m_wel = 0;
            end
            C_PP, C_SE, C_BE, C_CE: begin
              if (otp_mode) ok = m_wel && !m_lock;
              else if (cmd_op == C_CE) ok = m_wel && (m_bp == 0);
              else ok = m_wel && !(m_bp != 0 && in_region);
              if (ok) begin m_acc = 1; m_wip = 1; m_sr = 0; m_start = 1; end
              else m_wel = 0;
            end
            default: m_acc = 0;
          endcase
        end
      end
      if (fin) begin m_wip = 0; m_wel = 0; end
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (started && !finished) begin
      chk("R1 model status", status, mstat());
      chk("R12 model busy", busy, m_wip);
      chk("R2 model rsp_valid", rsp_valid, m_rv);
      chk("R2 model rsp_accept", rsp_accept, m_acc);
      chk("R2 model rsp_data", rsp_data, m_rdata);
      chk("R6 model arr_start", arr_start, m_start);
    end
  end

  // array engine stand-in
  int cd = 0;
  always @(negedge clk) begin
    array_done <= 1'b0;
    if (arr_start) cd = 3;
    else if (cd > 0) begin
      cd--;
      if (cd == 0) array_done <= 1'b1;
    end
  end

  task automatic issue(input logic [3:0] op, input logic [5:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = C_NONE;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset busy", busy, 0);

    issue(C_RDSR, 0);
    chk("R2 rdsr valid", rsp_valid, 1);
    chk("R2 rdsr accept", rsp_accept, 1);
    chk("R2 rdsr data", rsp_data, 8'h00);
    @(negedge clk);
    chk("R2 idle rsp_valid", rsp_valid, 0);

    issue(C_PP, 0);
    chk("R4 pp without wel", rsp_accept, 0);
    chk("R4 no start", arr_start, 0);

    issue(C_WREN, 0);
    chk("R3 wren accept", rsp_accept, 1);
    chk("R3 wel set", status, 8'h02);
    issue(4'd9, 0);
    chk("R2 unknown op rejected", rsp_accept, 0);
    chk("R2 unknown op no effect", status, 8'h02);
    issue(C_WRDI, 0);
    chk("R3 wel clear", status, 8'h00);
    issue(C_WREN, 0);

    issue(C_WRSR, 6'b000011);
    chk("R5 wrsr accept", rsp_accept, 1);
    chk("R5 wrsr status busy", status, 8'h0F);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk("R5 wip duration", cnt, WRC);
    chk("R5 after wrsr", status, 8'h0C);

    issue(C_WREN, 0);
    in_region = 1'b1;
    issue(C_PP, 0);
    chk("R6 protected pp rejected", rsp_accept, 0);
    chk("R13 wel cleared on reject", status, 8'h0C);

    issue(C_WREN, 0);
    in_region = 1'b0;
    issue(C_PP, 0);
    chk("R6 pp outside region accepted", rsp_accept, 1);
    chk("R6 arr_start", arr_start, 1);
    issue(C_WRDI, 0);
    chk("R12 wrdi ignored while busy", rsp_accept, 0);
    chk("R12 wel kept while busy", status, 8'h0F);
    issue(C_RDSR, 0);
    chk("R12 rdsr while busy", rsp_accept, 1);
    chk("R2 rdsr shows wip", rsp_data, 8'h0F);
    wait_idle();
    chk("R6 done clears wip wel", status, 8'h0C);

    issue(C_WREN, 0);
    issue(C_CE, 0);
    chk("R7 ce with pb set", rsp_accept, 0);

    issue(C_WREN, 0);
    issue(C_WRSR, 6'b100000);
    wait_idle();
    chk("R5 srp set", status, 8'h80);

    wp_n = 1'b0;
    issue(C_WREN, 0);
    issue(C_WRSR, 6'b000101);
    chk("R8 hw lock rejects", rsp_accept, 0);
    chk("R8 bits unchanged", status, 8'h80);

    wp_n = 1'b1;
    issue(C_WREN, 0);
    issue(C_WRSR, 6'b110000);
    wait_idle();
    chk("R9 wpdis set", status, 8'hC0);
    wp_n = 1'b0;
    issue(C_WREN, 0);
    issue(C_WRSR, 6'b100000);
    chk("R9 pin ignored", rsp_accept, 1);
    wait_idle();
    chk("R9 new bits", status, 8'h80);
    wp_n = 1'b1;

    issue(C_WREN, 0);
    issue(C_CE, 0);
    chk("R7 ce with pb zero", rsp_accept, 1);
    wait_idle();

    otp_mode = 1'b1;
    @(negedge clk);
    chk("R1 bit7 shows lock in otp", status, 8'h00);
    issue(C_WREN, 0);
    in_region = 1'b1;
    issue(C_PP, 0);
    chk("R11 otp pp unlocked", rsp_accept, 1);
    wait_idle();
    issue(C_WREN, 0);
    issue(C_WRSR, 6'b011111);
    chk("R10 otp wrsr accepted", rsp_accept, 1);
    wait_idle();
    chk("R10 lock set", status, 8'h80);
    otp_mode = 1'b0;
    @(negedge clk);
    chk("R10 data ignored", status, 8'h80);
    otp_mode = 1'b1;
    issue(C_WREN, 0);
    issue(C_SE, 0);
    chk("R11 otp erase locked", rsp_accept, 0);
    issue(C_WREN, 0);
    issue(C_CE, 0);
    chk("R11 otp ce locked", rsp_accept, 0);

    otp_mode = 1'b0;
    issue(C_WREN, 0);
    issue(C_WRSR, 6'b000000);
    wait_idle();
    chk("R5 srp cleared", status, 8'h00);
    otp_mode = 1'b1;
    @(negedge clk);
    chk("R11 lock sticky", status, 8'h80);
    otp_mode = 1'b0;
    in_region = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cmd_valid = (r < 70);
      r = $urandom_range(0, 11);
      cmd_op = (r >= 10) ? C_WREN : 4'(r);
      cmd_wdata = 6'($urandom_range(0, 63));
      wp_n = ($urandom_range(0, 3) != 0);
      in_region = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 49) == 0) otp_mode = ~otp_mode;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule